// File: doc/BRIEF.md
# SPI Master Interrupt Status Controller

This block collects every event an SPI master can raise into one status register, masks it with an enable register and drives a single interrupt line. Command completion, cancel completion, abort completion, the final-receive-word flag and seven error indications are edge sources. Each one latches its status bit on the rising edge of its input and keeps it until software clears it.

The two FIFO watermark sources are latched-level sources. Their bits are set again on every cycle in which the FIFO condition still holds, so a clear only takes effect once the condition has gone away. The block also holds three programmable FIFO thresholds: a transmit watermark, a receive watermark and a receive flow-control level. From the flow-control level it derives a registered ready-to-receive indication.

Software reaches the block through a simple single-cycle register port with separate read and write strobes. Read data appears one cycle after the read strobe.

Top module: `spim_irq_ctrl`

## Requirements
- R1: After reset the status and enable registers read 0, the transmit threshold reads 0, the receive threshold reads FIFO_DEPTH/2 (8 by default) and the flow-control threshold reads FIFO_DEPTH-2 (14 by default).
- R2: An edge source sets its status bit on the clock edge after its input rises. The bit stays set until it is cleared. An input that is held high does not set the bit again after a clear.
- R3: Status bit positions are: 0 command done, 1 cancel done, 2 abort done, 3 receive last, 4 transmit watermark, 5 receive watermark, and 6 to 12 for the error inputs err_i[0] to err_i[6].
- R4: Writing the clear register (address 1) clears each status bit written as 1 and leaves bits written as 0 unchanged. An event arriving on the same edge as a clear keeps its bit set.
- R5: The transmit watermark bit is set on every edge where tx_level_i <= the transmit threshold. A threshold of 0 disables this source.
- R6: The receive watermark bit is set on every edge where rx_level_i >= the receive threshold. A threshold of 0 disables this source.
- R7: Clearing a watermark bit while its condition still holds leaves the bit set.
- R8: irq_o is registered and always equals the OR of (status AND enable). The enable register is at address 2.
- R9: rx_ready_o is registered one cycle after the level is sampled. It is 1 when rx_level_i is below the flow-control threshold.
- R10: The register map is: 0 status (read only), 1 clear (reads 0), 2 enable, 3 transmit threshold, 4 receive threshold, 5 flow-control threshold. Read data is valid on the cycle after reg_rd_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, one cycle after the strobe |
| cmd_done_i | input | 1 | Command completed |
| cancel_done_i | input | 1 | Cancel completed |
| abort_done_i | input | 1 | Abort completed |
| rx_last_i | input | 1 | Final receive word present |
| err_i | input | 7 | Error indications (overrun, illegal, failure, rx read, rx write, tx read, tx write) |
| tx_level_i | input | LVL_W | Transmit FIFO occupancy |
| rx_level_i | input | LVL_W | Receive FIFO occupancy |
| irq_o | output | 1 | Interrupt line |
| rx_ready_o | output | 1 | Receive FIFO below flow-control level |

## Verification
A table of transmit and receive occupancy pairs is applied with fixed thresholds. Each pair is followed by a clear, and the bench checks which watermark bits survive. This separates the at-or-below transmit test from the at-or-above receive test, and shows that a persistent condition reasserts after a clear. Edge sources are held high across a clear to show they fire only once. An event is made to coincide with a clear to show that the event is kept. Walking error and completion pulses confirm the bit positions. Toggling the enable mask separates a set status bit from an asserted interrupt line.

// File: rtl/spim_irq_pkg.sv
package spim_irq_pkg;
  localparam int NUM_SRC = 13;
  localparam int NUM_ERR = 7;
  localparam int NUM_EDGE = 4 + NUM_ERR;
  localparam int ADDR_W = 3;
  localparam int B_TXWM = 4;
  localparam int B_RXWM = 5;
  localparam int B_ERR0 = 6;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS = 3'd0,
    SEL_CLEAR  = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_TXTHR  = 3'd3,
    SEL_RXTHR  = 3'd4,
    SEL_RFRTHR = 3'd5,
    SEL_NONE6  = 3'd6,
    SEL_NONE7  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/spim_irq_edge.sv
module spim_irq_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];

    // R2: an edge pulse never lasts two cycles
    a_r2_one_shot: assert property (@(posedge clk) disable iff (rst)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/spim_irq_thresh.sv
module spim_irq_thresh #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_tx_i,
  input  logic             wr_rx_i,
  input  logic             wr_rfr_i,
  input  logic [LVL_W-1:0] wval_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  output logic [LVL_W-1:0] tx_thr_o,
  output logic [LVL_W-1:0] rx_thr_o,
  output logic [LVL_W-1:0] rfr_thr_o,
  output logic             tx_hit_o,
  output logic             rx_hit_o,
  output logic             rx_ready_o
);
  localparam logic [LVL_W-1:0] RX_INIT  = LVL_W'(DEPTH / 2);
  localparam logic [LVL_W-1:0] RFR_INIT = LVL_W'(DEPTH - 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr_o   <= '0;
      rx_thr_o   <= RX_INIT;
      rfr_thr_o  <= RFR_INIT;
      rx_ready_o <= 1'b0;
    end else begin
      if (wr_tx_i)  tx_thr_o  <= wval_i;
      if (wr_rx_i)  rx_thr_o  <= wval_i;
      if (wr_rfr_i) rfr_thr_o <= wval_i;
      rx_ready_o <= (rx_level_i < rfr_thr_o);
    end
  end

  assign tx_hit_o = (tx_thr_o != '0) && (tx_level_i <= tx_thr_o);
  assign rx_hit_o = (rx_thr_o != '0) && (rx_level_i >= rx_thr_o);

  // R5: a zero transmit threshold keeps that source silent
  a_r5_tx_off: assert property (@(posedge clk) disable iff (rst)
    (tx_thr_o == '0) |-> !tx_hit_o);
  // R6: a zero receive threshold keeps that source silent
  a_r6_rx_off: assert property (@(posedge clk) disable iff (rst)
    (rx_thr_o == '0) |-> !rx_hit_o);
endmodule

// File: rtl/spim_irq_ctrl.sv
module spim_irq_ctrl
  import spim_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              cmd_done_i,
  input  logic              cancel_done_i,
  input  logic              abort_done_i,
  input  logic              rx_last_i,
  input  logic [NUM_ERR-1:0] err_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  output logic              irq_o,
  output logic              rx_ready_o
);
  reg_sel_e             sel;
  logic [NUM_EDGE-1:0]  rise;
  logic [NUM_SRC-1:0]   set_vec, clr_mask, stat_q, stat_d, en_q, en_d;
  logic [LVL_W-1:0]     tx_thr, rx_thr, rfr_thr;
  logic                 tx_hit, rx_hit;
  logic                 unused_wdata;

  assign sel          = reg_sel_e'(reg_addr_i);
  assign unused_wdata = ^reg_wdata_i;

  spim_irq_edge #(.N(NUM_EDGE)) edge_i (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  ({err_i, rx_last_i, abort_done_i, cancel_done_i, cmd_done_i}),
    .rise_o (rise)
  );

  spim_irq_thresh #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) thr_i (
    .clk        (clk),
    .rst        (rst),
    .wr_tx_i    (reg_wr_i && sel == SEL_TXTHR),
    .wr_rx_i    (reg_wr_i && sel == SEL_RXTHR),
    .wr_rfr_i   (reg_wr_i && sel == SEL_RFRTHR),
    .wval_i     (reg_wdata_i[LVL_W-1:0]),
    .tx_level_i (tx_level_i),
    .rx_level_i (rx_level_i),
    .tx_thr_o   (tx_thr),
    .rx_thr_o   (rx_thr),
    .rfr_thr_o  (rfr_thr),
    .tx_hit_o   (tx_hit),
    .rx_hit_o   (rx_hit),
    .rx_ready_o (rx_ready_o)
  );

  always_comb begin
    set_vec = '0;
    set_vec[3:0]                   = rise[3:0];
    set_vec[B_TXWM]                = tx_hit;
    set_vec[B_RXWM]                = rx_hit;
    set_vec[NUM_SRC-1:B_ERR0]      = rise[NUM_EDGE-1:4];
    clr_mask = (reg_wr_i && sel == SEL_CLEAR) ? reg_wdata_i[NUM_SRC-1:0] : '0;
    stat_d   = (stat_q & ~clr_mask) | set_vec;
    en_d     = (reg_wr_i && sel == SEL_ENABLE) ? reg_wdata_i[NUM_SRC-1:0] : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
      irq_o  <= |(stat_d & en_d);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
    end else if (reg_rd_i) begin
      case (sel)
        SEL_STATUS: reg_rdata_o <= DATA_W'(stat_q);
        SEL_ENABLE: reg_rdata_o <= DATA_W'(en_q);
        SEL_TXTHR:  reg_rdata_o <= DATA_W'(tx_thr);
        SEL_RXTHR:  reg_rdata_o <= DATA_W'(rx_thr);
        SEL_RFRTHR: reg_rdata_o <= DATA_W'(rfr_thr);
        default:    reg_rdata_o <= '0;
      endcase
    end
  end

  // R8: interrupt line tracks masked status
  a_r8_irq_match: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(stat_q & en_q));
  // R2: a bit not cleared never drops
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~stat_q & $past(stat_q & ~clr_mask)) == '0));
  // R4: a cleared bit without a coincident event is zero next cycle
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr_mask != '0) |=> ((stat_q & $past(clr_mask & ~set_vec)) == '0));
  // R7: a persisting transmit condition keeps its bit set
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (rst)
    tx_hit |=> stat_q[B_TXWM]);
  // R7: a persisting receive condition keeps its bit set
  a_r7_rx_hold: assert property (@(posedge clk) disable iff (rst)
    rx_hit |=> stat_q[B_RXWM]);
endmodule

// File: tb/spim_irq_ctrl_tb.sv
module spim_irq_ctrl_tb_top;
  localparam int LW = 5;
  logic clk = 1'b0, rst = 1'b1;
  logic wr = 0, rd = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic cmd = 0, cnl = 0, abt = 0, last = 0;
  logic [6:0] err = 0;
  logic [LW-1:0] txl = 0, rxl = 0;
  logic irq, rdy;
  int nchk = 0, nerr = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  spim_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cmd_done_i(cmd),
    .cancel_done_i(cnl), .abort_done_i(abt), .rx_last_i(last), .err_i(err),
    .tx_level_i(txl), .rx_level_i(rxl), .irq_o(irq), .rx_ready_o(rdy));

  // {tx level, rx level, expected {rx wm, tx wm}} with tx thr 4, rx thr 8
  localparam logic [11:0] VEC [6] = '{
    {5'd10, 5'd2,  2'b00}, {5'd4,  5'd2,  2'b01}, {5'd0, 5'd8,  2'b11},
    {5'd5,  5'd7,  2'b00}, {5'd3,  5'd16, 2'b11}, {5'd16, 5'd15, 2'b10}};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog got timeout exp finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    rreg(0, v); chk("R1 status", v, 0);
    rreg(2, v); chk("R1 enable", v, 0);
    rreg(3, v); chk("R1 tx thr", v, 0);
    rreg(4, v); chk("R1 rx thr", v, 8);
    rreg(5, v); chk("R1 rfr thr", v, 14);
    chk("R1 irq", {31'd0, irq}, 0);
    // R10 clear reads 0, thresholds read back
    rreg(1, v); chk("R10 clear reads 0", v, 0);
    wreg(3, 4);
    rreg(3, v); chk("R10 tx thr rd", v, 4);
    // R5 R6 R7 vector walk
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); txl = VEC[i][11:7]; rxl = VEC[i][6:2];
      tick;
      wreg(1, 32'h30);
      rreg(0, v);
      chk($sformatf("R5/R6/R7 vec%0d", i), {30'd0, v[5:4]}, {30'd0, VEC[i][1:0]});
    end
    // R5 disable via zero threshold
    @(negedge clk); txl = 0; rxl = 0;
    wreg(3, 0);
    wreg(1, 32'h30);
    rreg(0, v); chk("R5 thr zero disables", v & 32'h30, 0);
    // R2 held edge input fires once
    @(negedge clk); cmd = 1;
    rreg(0, v); chk("R2 cmd set", v, 32'h1);
    wreg(1, 32'h1);
    tick;
    rreg(0, v); chk("R2 held no reset", v, 0);
    @(negedge clk); cmd = 0;
    // R3 bit positions
    @(negedge clk); err = 7'b0000101; cnl = 1; last = 1;
    @(negedge clk); err = 0; cnl = 0; last = 0;
    rreg(0, v); chk("R3 positions", v, 32'h14A);
    // R4 partial clear leaves other bits
    wreg(1, 32'h40);
    rreg(0, v); chk("R4 partial clear", v, 32'h10A);
    // R4 event coincident with clear wins
    @(negedge clk); abt = 1; wr = 1; addr = 1; wdata = 32'h4;
    @(negedge clk); wr = 0; abt = 0;
    rreg(0, v); chk("R4 set wins", v & 32'h4, 32'h4);
    wreg(1, 32'h1FFF);
    rreg(0, v); chk("R4 all cleared", v, 0);
    // R8 irq masking
    @(negedge clk); cmd = 1;
    @(negedge clk); cmd = 0;
    chk("R8 masked", {31'd0, irq}, 0);
    wreg(2, 32'h1);
    chk("R8 enabled", {31'd0, irq}, 1);
    wreg(2, 32'h2);
    chk("R8 other enable", {31'd0, irq}, 0);
    wreg(1, 32'h1);
    wreg(2, 32'h20);
    @(negedge clk); rxl = 9;
    tick;
    chk("R8 rx wm irq", {31'd0, irq}, 1);
    // R9 flow control
    @(negedge clk); rxl = 13;
    tick;
    chk("R9 below", {31'd0, rdy}, 1);
    @(negedge clk); rxl = 14;
    tick;
    chk("R9 at level", {31'd0, rdy}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end
endmodule